// File: doc/BRIEF.md
# Link-Down Confirmation Sequencer

This block carries a link-down event from the phy layer up to the port layer through three chained state machines. A phy-reset machine leaves its setup or ready state and enters an out-of-band COMINIT state as soon as COMINIT is seen or dword synchronisation is lost. On entering that state it raises a Phy Layer Not Ready confirmation. An identification machine that is active then falls back to its Idle state. It raises Phy Disabled towards the port layer and sends a disable command to the connection-control machine. If a connection is open, that machine drops to Idle and raises Connection Closed.

A hard-reset request from the link is not passed straight through. It is held until the chain has gone quiet, so the port layer always sees Phy Disabled and Connection Closed before Hard Reset Received. Each stage is registered and adds one clock. Every confirmation is a single-cycle pulse.

Top module: `lrc_chain`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all four confirmation outputs and all three status outputs are 0. A reset also discards a hard-reset request that was waiting to be issued.
- R2: When `cominit_rx` or `sync_lost` is sampled high while the phy machine is in setup or ready, `phy_not_ready` is high for exactly the next cycle and `phy_up` reads 0 from that cycle on.
- R3: When `cominit_rx` or `sync_lost` is sampled high while the phy machine is already in its COMINIT state, `phy_not_ready` stays 0.
- R4: When `phy_not_ready` is high and the identification machine is active, `phy_disabled` is high in the following cycle and `ident_active` reads 0 from then on.
- R5: When `phy_not_ready` is high and the identification machine is already idle, `phy_disabled` stays 0.
- R6: When `phy_disabled` is high and a connection is open, `conn_closed` is high in the following cycle and `conn_active` reads 0 from then on.
- R7: When `phy_disabled` is high and no connection is open, `conn_closed` stays 0.
- R8: A rising edge on `hard_reset_det` while the chain is quiet raises `hard_reset_rcvd` for exactly the next cycle.
- R9: A hard-reset request is deferred while any confirmation is high or a link-down event is being sampled. It is issued at the first clock edge with none of these, so it is never high in the same cycle as, or the cycle right after, `conn_closed`. A request sampled together with a link-down event that travels the whole chain comes out two cycles after `conn_closed`.
- R10: `phy_ready` moves the phy machine to ready (`phy_up` = 1) one cycle later. `ident_done` activates identification one cycle later, but only while `phy_up` is 1. `conn_open` opens a connection one cycle later, but only while `ident_active` is 1.
- R11: Holding `hard_reset_det` high for several cycles produces a single `hard_reset_rcvd` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cominit_rx | input | 1 | COMINIT received from the phy |
| sync_lost | input | 1 | Dword synchronisation lost |
| phy_ready | input | 1 | Phy finished its reset and speed setup |
| ident_done | input | 1 | Identification exchange completed |
| conn_open | input | 1 | Request to open a connection |
| hard_reset_det | input | 1 | Hard reset detected on the link (level) |
| phy_not_ready | output | 1 | Phy Layer Not Ready confirmation pulse |
| phy_disabled | output | 1 | Phy Disabled confirmation pulse |
| conn_closed | output | 1 | Connection Closed confirmation pulse |
| hard_reset_rcvd | output | 1 | Hard Reset Received confirmation pulse |
| phy_up | output | 1 | Phy machine is in its ready state |
| ident_active | output | 1 | Identification machine is active |
| conn_active | output | 1 | Connection-control machine holds an open connection |

## Verification
A link-down event sampled at edge k shows `phy_not_ready` after edge k, `phy_disabled` after edge k+1 and `conn_closed` after edge k+2. A hard reset sampled with that event appears after edge k+4. A hard reset on a quiet chain appears after the very edge that samples it, and each status output moves one edge after its cause. The bench drives a vector on a falling edge and compares the outputs on the following falling edge, so every expected value belongs to exactly one rising edge. The vector table carries the multi-cycle orderings row by row. Directed steps cover reset in the middle of the chain and a hard-reset request that is pending when reset arrives.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

    typedef enum logic [1:0] {
        PHY_SETUP = 2'd0,
        PHY_OOB   = 2'd1,
        PHY_READY = 2'd2
    } phy_st_e;

    typedef enum logic {
        ID_IDLE   = 1'b0,
        ID_ACTIVE = 1'b1
    } id_st_e;

    typedef enum logic {
        CC_IDLE = 1'b0,
        CC_OPEN = 1'b1
    } cc_st_e;

    typedef struct packed {
        logic not_ready;
        logic disabled;
        logic closed;
    } chain_conf_t;

    function automatic logic link_down(input logic cominit, input logic lost);
        return cominit | lost;
    endfunction

    function automatic logic chain_busy(input chain_conf_t c, input logic evt);
        return evt | c.not_ready | c.disabled | c.closed;
    endfunction

endpackage

// File: rtl/lrc_phy_reset.sv
module lrc_phy_reset
    import lrc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    link_evt,
    input  logic    phy_ready,
    output logic    not_ready,
    output phy_st_e state
);
    phy_st_e state_d;
    logic    nr_d;

    always_comb begin
        state_d = state;
        nr_d    = 1'b0;
        if (link_evt) begin
            state_d = PHY_OOB;
            nr_d    = (state != PHY_OOB);
        end else if (phy_ready) begin
            state_d = PHY_READY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PHY_SETUP;
            not_ready <= 1'b0;
        end else begin
            state     <= state_d;
            not_ready <= nr_d;
        end
    end
endmodule

// File: rtl/lrc_ident_ctrl.sv
module lrc_ident_ctrl
    import lrc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   not_ready,
    input  logic   phy_is_up,
    input  logic   ident_done,
    output logic   disabled,
    output id_st_e state
);
    id_st_e state_d;
    logic   dis_d;

    always_comb begin
        state_d = state;
        dis_d   = 1'b0;
        if (not_ready) begin
            state_d = ID_IDLE;
            dis_d   = (state == ID_ACTIVE);
        end else if (state == ID_IDLE && ident_done && phy_is_up) begin
            state_d = ID_ACTIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ID_IDLE;
            disabled <= 1'b0;
        end else begin
            state    <= state_d;
            disabled <= dis_d;
        end
    end
endmodule

// File: rtl/lrc_conn_ctrl.sv
module lrc_conn_ctrl
    import lrc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   disable_cmd,
    input  logic   id_is_active,
    input  logic   conn_open,
    output logic   closed,
    output cc_st_e state
);
    cc_st_e state_d;
    logic   cl_d;

    always_comb begin
        state_d = state;
        cl_d    = 1'b0;
        if (disable_cmd) begin
            state_d = CC_IDLE;
            cl_d    = (state == CC_OPEN);
        end else if (state == CC_IDLE && conn_open && id_is_active) begin
            state_d = CC_OPEN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CC_IDLE;
            closed <= 1'b0;
        end else begin
            state  <= state_d;
            closed <= cl_d;
        end
    end
endmodule

// File: rtl/lrc_hreset_gate.sv
module lrc_hreset_gate
    import lrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hr_level,
    input  logic        link_evt,
    input  chain_conf_t conf,
    output logic        hr_rcvd
);
    logic level_q;
    logic pending;
    logic request;
    logic busy;

    assign request = hr_level & ~level_q;
    assign busy    = chain_busy(conf, link_evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            pending <= 1'b0;
            hr_rcvd <= 1'b0;
        end else begin
            level_q <= hr_level;
            if ((pending | request) && !busy) begin
                hr_rcvd <= 1'b1;
                pending <= 1'b0;
            end else begin
                hr_rcvd <= 1'b0;
                pending <= pending | request;
            end
        end
    end
endmodule

// File: rtl/lrc_chain.sv
module lrc_chain
    import lrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cominit_rx,
    input  logic sync_lost,
    input  logic phy_ready,
    input  logic ident_done,
    input  logic conn_open,
    input  logic hard_reset_det,
    output logic phy_not_ready,
    output logic phy_disabled,
    output logic conn_closed,
    output logic hard_reset_rcvd,
    output logic phy_up,
    output logic ident_active,
    output logic conn_active
);
    phy_st_e     phy_st;
    id_st_e      id_st;
    cc_st_e      cc_st;
    chain_conf_t conf;
    logic        evt;

    assign evt = link_down(cominit_rx, sync_lost);

    lrc_phy_reset u_phy (
        .clk       (clk),
        .rst       (rst),
        .link_evt  (evt),
        .phy_ready (phy_ready),
        .not_ready (conf.not_ready),
        .state     (phy_st)
    );

    lrc_ident_ctrl u_ident (
        .clk        (clk),
        .rst        (rst),
        .not_ready  (conf.not_ready),
        .phy_is_up  (phy_st == PHY_READY),
        .ident_done (ident_done),
        .disabled   (conf.disabled),
        .state      (id_st)
    );

    lrc_conn_ctrl u_conn (
        .clk          (clk),
        .rst          (rst),
        .disable_cmd  (conf.disabled),
        .id_is_active (id_st == ID_ACTIVE),
        .conn_open    (conn_open),
        .closed       (conf.closed),
        .state        (cc_st)
    );

    lrc_hreset_gate u_hr (
        .clk      (clk),
        .rst      (rst),
        .hr_level (hard_reset_det),
        .link_evt (evt),
        .conf     (conf),
        .hr_rcvd  (hard_reset_rcvd)
    );

    assign phy_not_ready = conf.not_ready;
    assign phy_disabled  = conf.disabled;
    assign conn_closed   = conf.closed;
    assign phy_up        = (phy_st == PHY_READY);
    assign ident_active  = (id_st == ID_ACTIVE);
    assign conn_active   = (cc_st == CC_OPEN);
endmodule

// File: rtl/lrc_chain_chk.sv
module lrc_chain_chk (
    input logic clk,
    input logic rst,
    input logic phy_not_ready,
    input logic phy_disabled,
    input logic conn_closed,
    input logic hard_reset_rcvd,
    input logic ident_active,
    input logic conn_active
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(phy_not_ready | phy_disabled | conn_closed | hard_reset_rcvd)); // R1

    AST_NR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        phy_not_ready |=> !phy_not_ready); // R3

    AST_DIS_AFTER_NR: assert property (@(posedge clk) disable iff (rst)
        phy_disabled |-> ($past(phy_not_ready) && !ident_active)); // R4

    AST_CLOSE_AFTER_DIS: assert property (@(posedge clk) disable iff (rst)
        conn_closed |-> ($past(phy_disabled) && !conn_active)); // R6

    AST_HR_QUIET: assert property (@(posedge clk) disable iff (rst)
        hard_reset_rcvd |-> !(phy_not_ready | phy_disabled | conn_closed)); // R9

    AST_HR_GAP: assert property (@(posedge clk) disable iff (rst)
        hard_reset_rcvd |-> !$past(conn_closed)); // R9

    AST_HR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hard_reset_rcvd |=> !hard_reset_rcvd); // R11
endmodule

bind lrc_chain lrc_chain_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .phy_not_ready   (phy_not_ready),
    .phy_disabled    (phy_disabled),
    .conn_closed     (conn_closed),
    .hard_reset_rcvd (hard_reset_rcvd),
    .ident_active    (ident_active),
    .conn_active     (conn_active)
);

// File: tb/lrc_chain_tb.sv
module lrc_chain_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cominit_rx = 1'b0, sync_lost = 1'b0, phy_ready = 1'b0;
    logic ident_done = 1'b0, conn_open = 1'b0, hard_reset_det = 1'b0;
    logic phy_not_ready, phy_disabled, conn_closed, hard_reset_rcvd;
    logic phy_up, ident_active, conn_active;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lrc_chain u_dut (
        .clk(clk), .rst(rst), .cominit_rx(cominit_rx), .sync_lost(sync_lost),
        .phy_ready(phy_ready), .ident_done(ident_done), .conn_open(conn_open),
        .hard_reset_det(hard_reset_det), .phy_not_ready(phy_not_ready),
        .phy_disabled(phy_disabled), .conn_closed(conn_closed),
        .hard_reset_rcvd(hard_reset_rcvd), .phy_up(phy_up),
        .ident_active(ident_active), .conn_active(conn_active)
    );

    // inputs  {hard_reset_det, conn_open, ident_done, phy_ready, sync_lost, cominit_rx}
    // expects {conn_active, ident_active, phy_up, hard_reset_rcvd, conn_closed, phy_disabled, phy_not_ready}
    localparam int NV = 29;
    localparam logic [12:0] VEC [NV] = '{
        {6'b011000, 7'b0000000},  // R10 nothing opens without phy up
        {6'b000100, 7'b0010000},  // R10
        {6'b001000, 7'b0110000},  // R10
        {6'b010000, 7'b1110000},  // R10
        {6'b100001, 7'b1100001},  // R2 with hard reset
        {6'b000000, 7'b1000010},  // R4
        {6'b000000, 7'b0000100},  // R6
        {6'b000000, 7'b0000000},  // R9 held back
        {6'b000000, 7'b0001000},  // R9 issued
        {6'b000000, 7'b0000000},
        {6'b000010, 7'b0000000},  // R3
        {6'b000100, 7'b0010000},  // R10
        {6'b000010, 7'b0000001},  // R2 via sync loss
        {6'b000000, 7'b0000000},  // R5
        {6'b100000, 7'b0001000},  // R8
        {6'b100000, 7'b0000000},  // R11
        {6'b000100, 7'b0010000},
        {6'b001000, 7'b0110000},
        {6'b000001, 7'b0100001},  // R2
        {6'b000000, 7'b0000010},  // R4
        {6'b000000, 7'b0000000},  // R7
        {6'b000100, 7'b0010000},
        {6'b001000, 7'b0110000},
        {6'b010000, 7'b1110000},
        {6'b000001, 7'b1100001},
        {6'b100000, 7'b1000010},  // R9 request mid-chain
        {6'b000000, 7'b0000100},  // R6
        {6'b000000, 7'b0000000},  // R9
        {6'b000000, 7'b0001000}   // R9
    };

    function automatic string req_of(input int b);
        case (b)
            0: return "R2/R3";
            1: return "R4/R5";
            2: return "R6/R7";
            3: return "R8/R9/R11";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [6:0] outs();
        return {conn_active, ident_active, phy_up, hard_reset_rcvd,
                conn_closed, phy_disabled, phy_not_ready};
    endfunction

    task automatic drive(input logic [5:0] v);
        {hard_reset_det, conn_open, ident_done, phy_ready, sync_lost, cominit_rx} = v;
    endtask

    task automatic check_all(input logic [6:0] exp, input string tag, input int idx);
        logic [6:0] act;
        act = outs();
        for (int b = 0; b < 7; b++) begin
            n_chk++;
            if (act[b] !== exp[b]) begin
                n_fail++;
                $display("FAIL %s step %0d bit %0d: actual %b expected %b",
                         (tag == "") ? req_of(b) : tag, idx, b, act[b], exp[b]);
            end
        end
    endtask

    initial begin
        drive(6'b0);
        repeat (3) @(negedge clk);
        check_all(7'b0, "R1", -1);                  // R1 reset state
        rst = 1'b0;
        @(negedge clk);
        check_all(7'b0, "R1", -2);                  // R1 first cycle after reset
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][12:7]);
            @(negedge clk);
            check_all(VEC[i][6:0], "", i);
        end
        // R1: reset in the middle of the chain, with a hard reset pending
        drive(6'b000100); @(negedge clk);
        drive(6'b001000); @(negedge clk);
        drive(6'b010000); @(negedge clk);
        drive(6'b100001); @(negedge clk);
        check_all(7'b1100001, "R1", 100);
        drive(6'b0);
        rst = 1'b1;
        @(negedge clk);
        check_all(7'b0, "R1", 101);
        rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check_all(7'b0, "R1", 102 + k);         // pending request discarded
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule